// File: doc/BRIEF.md
# Programmable System Clock Manager

This block decides which oscillator drives the processor core and which drives the peripherals. It divides the core clock by a programmable ratio. It also watches an external clock input and resets the system if that input goes quiet. Real clock nets are not switched. Each oscillator reaches the block as a one-cycle tick pulse, sampled on a fast system clock, that marks a rising edge of that source. The block answers with one-cycle enable pulses, `coreClkEn` and `periphClkEn`, that gate the downstream logic.

A 4-bit management register is loaded through a simple write strobe. Bit 3 keeps the peripherals running during sleep. Bit 2 forces the core onto internal RC oscillator 1. Bits 1:0 choose the core division ratio. A separate 2-bit oscillator field, `oscSel`, picks the oscillator for the core (when bit 2 is clear) and for the peripherals.

Every write to the register starts a resynchronisation. During it the core enable is held off until the newly selected source produces its first edge, so no shortened period reaches the core. A 1 ms reference tick times the external-clock supervisor.

Top module: `clkmgr_top`

## Requirements
- R1: After reset the management register reads 1111b, all three outputs are low, and the core runs from RC oscillator 1 divided by 8.
- R2: The core divide ratio is set by register bits 1:0: 00 gives 16, 01 gives 2, 10 gives 4 and 11 gives 8. `coreClkEn` pulses on every Nth edge of the core source.
- R3: While register bit 2 is 1, only `rc1Tick` advances the core divider, whatever `oscSel` holds.
- R4: While register bit 2 is 0, `oscSel` picks the core source: 11 is `extTick`, 01 is `rc2Tick`, 10 is `xtal4Tick` and 00 is `xtal32Tick`. Ticks of unselected sources have no effect.
- R5: A register write holds `coreClkEn` low. The first edge of the newly selected core source after the write ends this state and restarts the divider, so the first pulse comes N source edges after that edge.
- R6: In `oscSel` modes 11, 01 and 10, `periphClkEn` pulses on every 16th edge of `extTick`, `rc2Tick` or `xtal4Tick` respectively. A change of `oscSel` restarts this count.
- R7: In `oscSel` mode 00, `periphClkEn` pulses on every `xtal32Tick` edge.
- R8: While `sleepReq` is high and register bit 3 is 0, `periphClkEn` stays low and its divider holds. When bit 3 is 1, peripheral pulses continue during sleep.
- R9: While `sleepReq` is high, `coreClkEn` stays low and the core divider holds its count, so the count resumes where it stopped.
- R10: The supervisor runs only when `oscSel` is 11 and register bit 2 is 0. It raises `supvReset` for one cycle when a second `msTick` arrives with no `extTick` since the last `extTick`. An `extTick` restarts the window and wins over an `msTick` in the same cycle.
- R11: All outputs are registered. A tick applied in one cycle shows its effect on the outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rc1Tick | input | 1 | Edge pulse of internal RC oscillator 1 |
| rc2Tick | input | 1 | Edge pulse of trimmed RC oscillator 2 |
| xtal4Tick | input | 1 | Edge pulse of the 4 MHz crystal |
| xtal32Tick | input | 1 | Edge pulse of the 32 kHz crystal |
| extTick | input | 1 | Edge pulse of the external clock input |
| msTick | input | 1 | 1 ms reference pulse |
| sleepReq | input | 1 | Core sleep request |
| oscSel | input | 2 | Oscillator configuration field |
| regWrEn | input | 1 | Management register write strobe |
| regWrData | input | 4 | Management register write data |
| mgmtReg | output | 4 | Current management register value |
| coreClkEn | output | 1 | Core clock enable pulse |
| periphClkEn | output | 1 | Peripheral clock enable pulse |
| supvReset | output | 1 | Missing external clock reset pulse |

## Verification
The hardest state to reach is a core divider frozen partway through its count by sleep. It cannot be observed directly, so the stimulus ends a resynchronisation with a known edge and then feeds a chosen number of edges. It then sleeps through many more and wakes. The index of the first pulse after waking shows the held count. The supervisor window is built the same way, by interleaving external edges and reference ticks in a fixed order, so the exact tick that trips the reset is known in advance.

// File: rtl/clkmgr_pkg.sv
package clkmgr_pkg;

  localparam int REG_W   = 4;
  localparam int SPD_W   = 2;
  localparam int OSC_W   = 2;
  localparam int NUM_OSC = 1 << OSC_W;
  localparam int MAX_DIV = 16;
  localparam int DIV_W   = $clog2(MAX_DIV);

  localparam logic [OSC_W-1:0] OSC_X32 = 2'b00;
  localparam logic [OSC_W-1:0] OSC_RC2 = 2'b01;
  localparam logic [OSC_W-1:0] OSC_X4  = 2'b10;
  localparam logic [OSC_W-1:0] OSC_EXT = 2'b11;

  localparam int BIT_STOPP = 3;
  localparam int BIT_CSEL  = 2;

  localparam logic [REG_W-1:0] REG_RESET = 4'b1111;

  typedef struct packed {
    logic             syncing;
    logic             divClear;
    logic [SPD_W-1:0] speed;
    logic             coreSel;
    logic             keepPeriph;
    logic             sleeping;
  } ctlStrobe_t;

  // terminal count (ratio - 1) for a speed code
  function automatic logic [DIV_W-1:0] divLimit(input logic [SPD_W-1:0] spd);
    case (spd)
      2'b00:   return DIV_W'(15);
      2'b01:   return DIV_W'(1);
      2'b10:   return DIV_W'(3);
      default: return DIV_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/clkmgr_ctrl.sv
module clkmgr_ctrl
  import clkmgr_pkg::*;
#(
  parameter int MISS_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic [OSC_W-1:0] oscSel,
  input  logic             sleepReq,
  input  logic             extTick,
  input  logic             msTick,
  input  logic             coreSrcTick,
  output ctlStrobe_t       strobe,
  output logic [REG_W-1:0] mgmtReg,
  output logic             supvReset
);

  localparam int MISS_W = $clog2(MISS_TICKS + 1);

  logic [REG_W-1:0]  regQ;
  logic              syncQ;
  logic [MISS_W-1:0] missCnt;
  logic              supvActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ  <= REG_RESET;
      syncQ <= 1'b0;
    end else if (regWrEn) begin
      regQ  <= regWrData;
      syncQ <= 1'b1;
    end else if (syncQ && coreSrcTick) begin
      syncQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.syncing    = syncQ;
    strobe.divClear   = regWrEn | (syncQ & coreSrcTick);
    strobe.speed      = regQ[SPD_W-1:0];
    strobe.coreSel    = regQ[BIT_CSEL];
    strobe.keepPeriph = regQ[BIT_STOPP];
    strobe.sleeping   = sleepReq;
  end

  assign mgmtReg    = regQ;
  assign supvActive = (oscSel == OSC_EXT) && !regQ[BIT_CSEL];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCnt   <= '0;
      supvReset <= 1'b0;
    end else if (!supvActive || extTick) begin
      missCnt   <= '0;
      supvReset <= 1'b0;
    end else if (msTick) begin
      if (missCnt == MISS_W'(MISS_TICKS - 1)) begin
        missCnt   <= '0;
        supvReset <= 1'b1;
      end else begin
        missCnt   <= missCnt + 1'b1;
        supvReset <= 1'b0;
      end
    end else begin
      supvReset <= 1'b0;
    end
  end

endmodule

// File: rtl/clkmgr_datapath.sv
module clkmgr_datapath
  import clkmgr_pkg::*;
#(
  parameter int PERIPH_DIV = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rc1Tick,
  input  logic [NUM_OSC-1:0] oscTicks,
  input  logic [OSC_W-1:0]   oscSel,
  input  ctlStrobe_t         strobe,
  output logic               coreSrcTick,
  output logic               coreClkEn,
  output logic               periphClkEn
);

  localparam int PDIV_W = (PERIPH_DIV > 1) ? $clog2(PERIPH_DIV) : 1;

  logic [DIV_W-1:0]  coreCnt;
  logic [DIV_W-1:0]  coreLim;
  logic              coreHit;
  logic              selOscTick;
  logic [PDIV_W-1:0] perCnt;
  logic [OSC_W-1:0]  prevOsc;
  logic              perRaw;
  logic              perGate;

  assign selOscTick  = oscTicks[oscSel];
  assign coreSrcTick = strobe.coreSel ? rc1Tick : selOscTick;
  assign coreLim     = divLimit(strobe.speed);
  assign coreHit     = coreSrcTick && !strobe.syncing && !strobe.sleeping
                       && (coreCnt == coreLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreCnt   <= '0;
      coreClkEn <= 1'b0;
    end else begin
      coreClkEn <= coreHit;
      if (strobe.divClear)
        coreCnt <= '0;
      else if (coreSrcTick && !strobe.sleeping && !strobe.syncing)
        coreCnt <= coreHit ? '0 : coreCnt + 1'b1;
    end
  end

  assign perGate = strobe.sleeping && !strobe.keepPeriph;

  generate
    if (PERIPH_DIV > 1) begin : g_perDiv
      always_comb begin
        if (oscSel == OSC_X32)
          perRaw = selOscTick;
        else
          perRaw = selOscTick && (perCnt == PDIV_W'(PERIPH_DIV - 1));
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          perCnt  <= '0;
          prevOsc <= OSC_X32;
        end else begin
          prevOsc <= oscSel;
          if (oscSel != prevOsc || oscSel == OSC_X32)
            perCnt <= '0;
          else if (selOscTick && !perGate)
            perCnt <= (perCnt == PDIV_W'(PERIPH_DIV - 1)) ? '0 : perCnt + 1'b1;
        end
      end
    end else begin : g_perPass
      assign perRaw = selOscTick;
      always_ff @(posedge clk) begin
        perCnt  <= '0;
        prevOsc <= oscSel;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) periphClkEn <= 1'b0;
    else       periphClkEn <= perRaw && !perGate && (oscSel == prevOsc);
  end

endmodule

// File: rtl/clkmgr_top.sv
module clkmgr_top
  import clkmgr_pkg::*;
#(
  parameter int MISS_TICKS = 2,
  parameter int PERIPH_DIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rc1Tick,
  input  logic       rc2Tick,
  input  logic       xtal4Tick,
  input  logic       xtal32Tick,
  input  logic       extTick,
  input  logic       msTick,
  input  logic       sleepReq,
  input  logic [1:0] oscSel,
  input  logic       regWrEn,
  input  logic [3:0] regWrData,
  output logic [3:0] mgmtReg,
  output logic       coreClkEn,
  output logic       periphClkEn,
  output logic       supvReset
);

  ctlStrobe_t         strobe;
  logic               coreSrcTick;
  logic [NUM_OSC-1:0] oscTicks;

  always_comb begin
    oscTicks          = '0;
    oscTicks[OSC_X32] = xtal32Tick;
    oscTicks[OSC_RC2] = rc2Tick;
    oscTicks[OSC_X4]  = xtal4Tick;
    oscTicks[OSC_EXT] = extTick;
  end

  clkmgr_ctrl #(.MISS_TICKS(MISS_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .oscSel(oscSel), .sleepReq(sleepReq), .extTick(extTick), .msTick(msTick),
    .coreSrcTick(coreSrcTick), .strobe(strobe), .mgmtReg(mgmtReg),
    .supvReset(supvReset)
  );

  clkmgr_datapath #(.PERIPH_DIV(PERIPH_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .rc1Tick(rc1Tick), .oscTicks(oscTicks),
    .oscSel(oscSel), .strobe(strobe), .coreSrcTick(coreSrcTick),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn)
  );

endmodule

// File: rtl/clkmgr_checker.sv
module clkmgr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sleepReq,
  input logic [1:0] oscSel,
  input logic       regWrEn,
  input logic [3:0] mgmtReg,
  input logic       coreClkEn,
  input logic       periphClkEn,
  input logic       supvReset
);

  a_r9_sleep_core_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !coreClkEn);

  a_r8_sleep_periph_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !mgmtReg[3]) |=> !periphClkEn);

  a_r10_supv_config_only: assert property (@(posedge clk) disable iff (!rstN)
    !(oscSel == 2'b11 && !mgmtReg[2]) |=> !supvReset);

  a_r10_supv_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    supvReset |=> !supvReset);

  a_r5_write_holds_core: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> ##1 !coreClkEn);

endmodule

bind clkmgr_top clkmgr_checker u_chk (
  .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .oscSel(oscSel),
  .regWrEn(regWrEn), .mgmtReg(mgmtReg), .coreClkEn(coreClkEn),
  .periphClkEn(periphClkEn), .supvReset(supvReset)
);

// File: tb/clkmgr_top_test.sv
module clkmgr_top_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rc1Tick = 0, rc2Tick = 0, xtal4Tick = 0, xtal32Tick = 0, extTick = 0;
  logic       msTick = 0, sleepReq = 0, regWrEn = 0;
  logic [1:0] oscSel = 2'b00;
  logic [3:0] regWrData = 4'h0;
  logic [3:0] mgmtReg;
  logic       coreClkEn, periphClkEn, supvReset;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  clkmgr_top uut (
    .clk(clk), .rstN(rstN), .rc1Tick(rc1Tick), .rc2Tick(rc2Tick),
    .xtal4Tick(xtal4Tick), .xtal32Tick(xtal32Tick), .extTick(extTick),
    .msTick(msTick), .sleepReq(sleepReq), .oscSel(oscSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .mgmtReg(mgmtReg), .coreClkEn(coreClkEn),
    .periphClkEn(periphClkEn), .supvReset(supvReset)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setTick(input int which, input logic v);
    case (which)
      0: xtal32Tick = v;
      1: rc2Tick    = v;
      2: xtal4Tick  = v;
      3: extTick    = v;
      default: rc1Tick = v;
    endcase
  endtask

  // which: 0 x32, 1 rc2, 2 x4, 3 ext, 4 rc1
  task automatic runTicks(input int which, input int n,
                          output int corePulses, output int coreFirst,
                          output int perPulses);
    corePulses = 0; coreFirst = 0; perPulses = 0;
    for (int i = 1; i <= n; i++) begin
      setTick(which, 1'b1);
      step();
      if (coreClkEn) begin
        corePulses++;
        if (coreFirst == 0) coreFirst = i;
      end
      if (periphClkEn) perPulses++;
      setTick(which, 1'b0);
      step();
      if (coreClkEn) corePulses += 100;
      if (periphClkEn) perPulses += 100;
    end
  endtask

  task automatic writeReg(input logic [3:0] v);
    regWrEn = 1'b1; regWrData = v;
    step();
    regWrEn = 1'b0;
    step();
  endtask

  task automatic testReset();
    check("R1 register reset", mgmtReg, 4'hF);
    check("R1 core enable low", coreClkEn, 0);
    check("R1 periph enable low", periphClkEn, 0);
    check("R1 supervisor low", supvReset, 0);
  endtask

  task automatic testDefaultDiv();
    int cp, cf, pp;
    runTicks(4, 16, cp, cf, pp);
    check("R1 default div8 pulses", cp, 2);
    check("R11 R1 first pulse on 8th tick", cf, 8);
  endtask

  task automatic testDivides();
    int cp, cf, pp;
    logic [1:0] codes [4] = '{2'b00, 2'b11, 2'b10, 2'b01};
    int ratios [4] = '{16, 8, 4, 2};
    for (int k = 0; k < 4; k++) begin
      writeReg({2'b11, codes[k]});
      check("R5 enable held after write", coreClkEn, 0);
      runTicks(4, 33, cp, cf, pp);
      check("R2 pulse count", cp, 32 / ratios[k]);
      check("R5 R2 first pulse index", cf, ratios[k] + 1);
    end
  endtask

  task automatic testSources();
    int cp, cf, pp;
    for (int m = 0; m < 4; m++) begin
      oscSel = 2'(m);
      writeReg(4'b0011);
      runTicks(4, 10, cp, cf, pp);
      check("R4 rc1 ignored when core select 0", cp, 0);
      runTicks(m, 17, cp, cf, pp);
      check("R4 selected source pulses", cp, 2);
      check("R4 selected source first", cf, 9);
    end
    oscSel = 2'b10;
    writeReg(4'b0111);
    runTicks(2, 17, cp, cf, pp);
    check("R3 x4 ignored when core select 1", cp, 0);
    runTicks(4, 17, cp, cf, pp);
    check("R3 rc1 drives core", cp, 2);
  endtask

  task automatic testPeriph();
    int cp, cf, pp;
    int srcs [3] = '{2, 1, 3};
    for (int k = 0; k < 3; k++) begin
      oscSel = 2'(srcs[k]);
      step(); step();
      runTicks(srcs[k], 32, cp, cf, pp);
      check("R6 periph divide by 16", pp, 2);
    end
    oscSel = 2'b00;
    step(); step();
    runTicks(0, 5, cp, cf, pp);
    check("R7 periph follows 32k", pp, 5);
  endtask

  task automatic testSleep();
    int cp, cf, pp;
    oscSel = 2'b00;
    writeReg(4'b0111);
    sleepReq = 1'b1;
    runTicks(0, 4, cp, cf, pp);
    check("R8 periph stopped in sleep", pp, 0);
    sleepReq = 1'b0;
    writeReg(4'b1111);
    sleepReq = 1'b1;
    runTicks(0, 4, cp, cf, pp);
    check("R8 periph kept in sleep", pp, 4);
    sleepReq = 1'b0;
    runTicks(4, 5, cp, cf, pp);
    check("R9 pre-sleep no pulse", cp, 0);
    sleepReq = 1'b1;
    runTicks(4, 10, cp, cf, pp);
    check("R9 core quiet in sleep", cp, 0);
    sleepReq = 1'b0;
    runTicks(4, 4, cp, cf, pp);
    check("R9 divider held through sleep", cf, 4);
  endtask

  task automatic msPulse(output int seen);
    msTick = 1'b1;
    step();
    msTick = 1'b0;
    seen = supvReset;
    step();
    seen += supvReset ? 10 : 0;
  endtask

  task automatic extPulse();
    extTick = 1'b1; step(); extTick = 1'b0; step();
  endtask

  task automatic testSupervisor();
    int s;
    oscSel = 2'b11;
    writeReg(4'b0011);
    msPulse(s);
    check("R10 one ms no reset", s, 0);
    msPulse(s);
    check("R10 reset on second ms", s, 1);
    extPulse();
    msPulse(s);
    check("R10 window restarted", s, 0);
    extPulse();
    msPulse(s);
    check("R10 ext restarts again", s, 0);
    extTick = 1'b1; msTick = 1'b1;
    step();
    extTick = 1'b0; msTick = 1'b0;
    check("R10 ext wins same cycle", supvReset, 0);
    step();
    msPulse(s);
    check("R10 reset after tie", s, 0);
    msPulse(s);
    check("R10 reset after two quiet ms", s, 1);
    oscSel = 2'b10;
    step();
    msPulse(s); msPulse(s); msPulse(s);
    check("R10 inactive other mode", s, 0);
    oscSel = 2'b11;
    writeReg(4'b0111);
    msPulse(s); msPulse(s); msPulse(s);
    check("R10 inactive core select 1", s, 0);
  endtask

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    testReset();
    testDefaultDiv();
    testDivides();
    testSources();
    testPeriph();
    testSleep();
    testSupervisor();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule